// File: doc/BRIEF.md
# SPI Controller with Status-Flag Handshake

This block is a register-mapped SPI peripheral for a small 8-bit processor bus. Software programs a control register, writes a byte to the data register to launch a transfer and learns of its completion from a status flag or an interrupt line. As a master, the block divides the system clock down to a serial clock and shifts the byte out most-significant bit first while collecting a byte from the input line. As a slave, it follows an external serial clock whenever its select input is held low.

The status flags follow a strict two-step clearing rule. A flag clears only when software first reads the status register while the flag is set, and then accesses the data register. While a finished transfer has not been acknowledged this way, writes to the data register are dropped. A master whose select input is pulled low by another master records a mode fault. It then gives up master mode and releases its outputs.

The register port is plain and has no back-pressure. A read or write completes in the cycle its strobe is high. Read data depends only on the address, and every side effect of a read happens at the clock edge that samples the strobe.

Top module: `spi_hs_ctrl`

## Requirements
- R1: After reset, the control, status and data registers all read 0x00. `irq` is low and `sck_oe`, `mosi_oe` and `miso_oe` are all low.
- R2: Register addresses are 0 for control, 1 for status and 2 for data. The control byte holds enable in bit 0, interrupt enable in bit 1, master in bit 2, clock polarity in bit 3, clock phase in bit 4 and rate in bits 6:5. In master mode, `sck_o` rests at the polarity bit outside a transfer and toggles exactly 16 times per byte.
- R3: In master mode, a rate of 0, 1, 2 or 3 gives an SCK half-period of 1, 2, 8 or 16 system clocks. The transfer-complete flag therefore sets exactly 16×half clock cycles after the clock edge that samples the data write.
- R4: With phase 0, the first bit is on `mosi_o` before the first SCK edge and data is sampled on leading edges. With phase 1, data changes on leading edges and is sampled on trailing edges. Bits go MSB first, and the byte gathered from `miso_i` is what the data register then reads.
- R5: The transfer-complete flag (status bit 7) sets when a byte finishes. `irq` is high exactly while that flag and the interrupt-enable bit are both set.
- R6: The transfer-complete flag clears only after a status read that sees it set, followed by a data-register read or write. A data access with no such earlier status read leaves the flag set.
- R7: A data-register write made while the transfer-complete flag is set, with no acknowledging status read first, is discarded and starts nothing.
- R8: A data write accepted during a transfer sets the write-collision flag (status bit 6) and leaves the byte being shifted unchanged. The flag clears through the same status-read-then-data-access sequence.
- R9: The mode-fault flag is status bit 4. Every other status bit reads 0.
- R10: In slave mode, the byte moves on `sck_i`/`mosi_i` while `ss_n_i` is low and `miso_o` carries the preloaded byte. `miso_oe` is high only while selected. The rate field has no effect in this mode.
- R11: A low `ss_n_i` while the block is an enabled master sets the mode-fault flag, clears the master bit and drops `sck_oe` and `mosi_oe`. The flag clears after a status read that sees it, followed by a control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select (0 control, 1 status, 2 data) |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; its side effects land at the sampling edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Transfer-complete interrupt request |
| sck_i | input | 1 | Serial clock from an external master (slave mode) |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Drive enable for `sck_o` |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| mosi_oe | output | 1 | Drive enable for `mosi_o` |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | Drive enable for `miso_o` |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The bench targets the acknowledge sequence. A design that clears the transfer-complete flag on any data access, or that lets an unacknowledged data write start a transfer, shows a flag that vanishes early or SCK edges where none should appear. A write collision is forced mid-transfer, so a design that reloads the shifter sends a corrupted byte, and one that ignores the collision leaves status bit 6 clear. All four rate codes are timed to the exact cycle, and both phases are run under both polarities against a bench-side partner, which catches bits sampled on the wrong edge. The bench also checks that the slave runs the same with the rate field at extremes, and that a mode fault drops the drivers and the master bit.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;

  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int DIV_W   = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  // control byte layout, bit 7 down to bit 0
  typedef struct packed {
    logic       rsvd;
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       irq_en;
    logic       enable;
  } ctrl_t;

  // serial clock half-period in system clocks, minus one
  function automatic logic [DIV_W-1:0] half_m1(input logic [1:0] rate);
    case (rate)
      2'd0:    half_m1 = DIV_W'(0);
      2'd1:    half_m1 = DIV_W'(1);
      2'd2:    half_m1 = DIV_W'(7);
      default: half_m1 = DIV_W'(15);
    endcase
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[0] <= RST_VAL;
        else        st_q[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= {st_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = half_m1(rate);
  assign tick  = run && (div_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (!run||tick) div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end

  // slower rates never produce edges on back-to-back cycles
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate != 2'd0) |=> !tick);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              go,
  input  logic              abort,
  input  logic              cpha,
  input  logic              edge_stb,
  input  logic              in_bit,
  output logic              out_bit,
  output logic              running,
  output logic              phase,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);

  localparam int EDGES = 2 * DATA_W;
  localparam int CW    = $clog2(EDGES);

  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic              leading, sample_now, drive_now, last_edge;
  logic [DATA_W-1:0] rx_next;

  assign leading    = ~cnt_q[0];
  assign sample_now = edge_stb & (leading ^ cpha);
  assign drive_now  = edge_stb & ~(leading ^ cpha);
  assign last_edge  = (cnt_q == CW'(EDGES-1));
  assign rx_next    = {rx_q[DATA_W-2:0], in_bit};
  assign done       = edge_stb & last_edge & ~abort & ~load;
  assign phase      = cnt_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rx_data <= '0;
      out_bit <= 1'b0;
      running <= 1'b0;
    end else if (load) begin
      cnt_q   <= '0;
      running <= go;
      if (cpha) begin
        tx_q <= load_data;
      end else begin
        tx_q    <= {load_data[DATA_W-2:0], 1'b0};
        out_bit <= load_data[DATA_W-1];
      end
    end else if (abort) begin
      cnt_q   <= '0;
      running <= 1'b0;
    end else if (edge_stb) begin
      running <= ~last_edge;
      cnt_q   <= last_edge ? '0 : cnt_q + 1'b1;
      if (sample_now) rx_q <= rx_next;
      if (drive_now) begin
        out_bit <= tx_q[DATA_W-1];
        tx_q    <= {tx_q[DATA_W-2:0], 1'b0};
      end
      if (last_edge) rx_data <= sample_now ? rx_next : rx_q;
    end
  end

  assert_load_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !running);

  assert_done_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !running);

endmodule

// File: rtl/spi_hs_ctrl.sv
module spi_hs_ctrl
  import spi_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i
);

  ctrl_t ctrl_q;
  logic  spif_q, wcol_q, modf_q;
  logic  spif_seen_q, wcol_seen_q, modf_seen_q;
  logic  sck_prev_q;

  logic        ss_n_s, mosi_s, sck_s;
  logic        wr_ctrl, rd_stat, wr_data, acc_data;
  logic        master_on, slave_on, slave_sel, mode_fault;
  logic        wr_blocked, wr_ok, busy, collide, xfer_done;
  logic        tick, edge_stb, abort, load, in_bit, out_bit, phase;
  logic [BYTE_W-1:0] rx_byte;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n_i, mosi_i, sck_i}),
    .q({ss_n_s, mosi_s, sck_s})
  );

  // bus decode
  assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  assign rd_stat  = reg_rd && reg_addr == A_STAT;
  assign wr_data  = reg_wr && reg_addr == A_DATA;
  assign acc_data = (reg_wr || reg_rd) && reg_addr == A_DATA;

  assign master_on  = ctrl_q.enable & ctrl_q.master;
  assign slave_on   = ctrl_q.enable & ~ctrl_q.master;
  assign slave_sel  = slave_on & ~ss_n_s;
  assign mode_fault = master_on & ~ss_n_s;

  assign wr_blocked = spif_q & ~spif_seen_q;
  assign wr_ok      = wr_data & ~wr_blocked;
  assign collide    = wr_ok & busy;
  assign load       = wr_ok & ~busy;

  assign abort    = mode_fault | ~ctrl_q.enable | (slave_on & ss_n_s);
  assign edge_stb = master_on ? tick : (slave_sel & (sck_s ^ sck_prev_q));
  assign in_bit   = master_on ? miso_i : mosi_s;

  spi_rate_gen u_rate (
    .clk(clk), .rst_n(rst_n),
    .run(master_on & busy),
    .rate(ctrl_q.rate),
    .tick(tick)
  );

  spi_shifter #(.DATA_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_data(reg_wdata),
    .go(master_on & ~mode_fault),
    .abort(abort), .cpha(ctrl_q.cpha),
    .edge_stb(edge_stb), .in_bit(in_bit),
    .out_bit(out_bit), .running(busy), .phase(phase),
    .done(xfer_done), .rx_data(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= sck_s;
  end

  // control register; a mode fault overrides the master bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q      <= ctrl_t'(reg_wdata);
        ctrl_q.rsvd <= 1'b0;
      end
      if (mode_fault) ctrl_q.master <= 1'b0;
    end
  end

  // status flags: set wins over the acknowledge sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spif_q      <= 1'b0;
      wcol_q      <= 1'b0;
      modf_q      <= 1'b0;
      spif_seen_q <= 1'b0;
      wcol_seen_q <= 1'b0;
      modf_seen_q <= 1'b0;
    end else begin
      if (xfer_done)                     spif_q <= 1'b1;
      else if (acc_data && spif_seen_q)  spif_q <= 1'b0;

      if (collide)                       wcol_q <= 1'b1;
      else if (acc_data && wcol_seen_q)  wcol_q <= 1'b0;

      if (mode_fault)                    modf_q <= 1'b1;
      else if (wr_ctrl && modf_seen_q)   modf_q <= 1'b0;

      if (rd_stat) begin
        spif_seen_q <= spif_q;
        wcol_seen_q <= wcol_q;
        modf_seen_q <= modf_q;
      end else begin
        if (acc_data) begin
          spif_seen_q <= 1'b0;
          wcol_seen_q <= 1'b0;
        end
        if (wr_ctrl) modf_seen_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {spif_q, wcol_q, 1'b0, modf_q, 4'b0000};
      A_DATA:  reg_rdata = rx_byte;
      default: reg_rdata = '0;
    endcase
  end

  assign irq     = spif_q & ctrl_q.irq_en;
  assign sck_o   = ctrl_q.cpol ^ phase;
  assign sck_oe  = master_on;
  assign mosi_o  = out_bit;
  assign mosi_oe = master_on;
  assign miso_o  = out_bit;
  assign miso_oe = slave_sel;

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_on && !busy) |-> (sck_o == ctrl_q.cpol));

  assert_spif_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif_q) |-> $past(xfer_done));

  assert_blocked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && spif_q && !spif_seen_q && !busy && master_on) |=> !busy);

  assert_wcol_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy && !(spif_q && !spif_seen_q)) |=> wcol_q);

  assert_modf_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> (!sck_oe && !mosi_oe && modf_q));

endmodule

// File: tb/spi_hs_ctrl_tb.sv
module spi_hs_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  logic       cfg_cpol = 0, cfg_cpha = 0, sck_last = 0;
  int         mon_edges = 0;
  logic [7:0] mon_cap = '0, slv_sh = '0;

  spi_hs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  always #10 clk = ~clk;

  // bench-side slave partner for master transfers
  always @(negedge clk) begin
    if (sck_oe && sck_o !== sck_last) begin
      mon_edges = mon_edges + 1;
      if ((sck_o != cfg_cpol) ^ cfg_cpha) mon_cap = {mon_cap[6:0], mosi_o};
      else begin
        miso_i = slv_sh[7];
        slv_sh = {slv_sh[6:0], 1'b0};
      end
    end
    sck_last = sck_o;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      summary();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [7:0] cbyte(input logic en, ie, ms, pol, ph, input logic [1:0] rt);
    return {1'b0, rt, ph, pol, ms, ie, en};
  endfunction

  task automatic setup_master(input logic pol, ph, ie, input logic [1:0] rt, input logic [7:0] sx);
    reg_write(2'd0, cbyte(1, ie, 1, pol, ph, rt));
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = ph; mon_edges = 0; mon_cap = '0; slv_sh = sx;
    if (!ph) begin miso_i = sx[7]; slv_sh = {sx[6:0], 1'b0}; end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_read(2'd0, d); check("R1 ctrl after reset", d, 8'h00);
    reg_read(2'd1, d); check("R1 status after reset", d, 8'h00);
    reg_read(2'd2, d); check("R1 data after reset", d, 8'h00);
    check("R1 irq and enables", {irq, sck_oe, mosi_oe, miso_oe}, 4'b0000);
  endtask

  task automatic t_master(input logic pol, ph, input logic [1:0] rt, input logic [7:0] tx, sx);
    int h, n;
    logic [7:0] d;
    h = (rt == 0) ? 1 : (rt == 1) ? 2 : (rt == 2) ? 8 : 16;
    setup_master(pol, ph, 1'b1, rt, sx);
    check("R2 sck idle before", sck_o, pol);
    reg_write(2'd2, tx);
    n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    check("R3 cycles to done", n, 16 * h);
    @(negedge clk);
    check("R2 edge count", mon_edges, 16);
    check("R2 sck idle after", sck_o, pol);
    check("R4 mosi byte seen by partner", mon_cap, tx);
    reg_read(2'd1, d); check("R5 status after done", d, 8'h80);
    reg_read(2'd2, d); check("R4 byte received from miso", d, sx);
    reg_read(2'd1, d); check("R6 status cleared by sequence", d, 8'h00);
    check("R5 irq dropped", irq, 1'b0);
  endtask

  task automatic t_handshake();
    logic [7:0] d;
    setup_master(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    reg_write(2'd2, 8'h5A);
    repeat (40) @(negedge clk);
    check("R5 irq masked by enable bit", irq, 1'b0);
    mon_edges = 0;
    reg_write(2'd2, 8'hC3);
    repeat (40) @(negedge clk);
    check("R7 unacknowledged write starts nothing", mon_edges, 0);
    reg_read(2'd2, d);
    reg_read(2'd1, d); check("R6 flag survives bare data access", d, 8'h80);
    mon_edges = 0; mon_cap = '0;
    reg_write(2'd2, 8'h96);
    repeat (40) @(negedge clk);
    check("R7 acknowledged write transfers", {mon_edges[7:0], mon_cap}, {8'd16, 8'h96});
    reg_read(2'd1, d);
    reg_read(2'd2, d);
    reg_read(2'd1, d); check("R6 status clean after sequence", d, 8'h00);
  endtask

  task automatic t_wcol();
    logic [7:0] d;
    int n;
    setup_master(1'b0, 1'b1, 1'b1, 2'd2, 8'h00);
    reg_write(2'd2, 8'hB1);
    repeat (10) @(negedge clk);
    reg_write(2'd2, 8'h4E);
    n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    check("R8 shift undisturbed by collision", {mon_edges[7:0], mon_cap}, {8'd16, 8'hB1});
    reg_read(2'd1, d); check("R8 collision flag set", d, 8'hC0);
    reg_read(2'd2, d);
    reg_read(2'd1, d); check("R8 collision flag cleared", d, 8'h00);
  endtask

  task automatic t_slave(input logic pol, ph, input logic [1:0] rt, input logic [7:0] mtx, stx);
    logic [7:0] d, cap;
    ss_n_i = 1'b1; sck_i = pol; mosi_i = 1'b0;
    reg_write(2'd0, cbyte(1, 1, 0, pol, ph, rt));
    reg_write(2'd2, stx);
    check("R10 miso released when not selected", miso_oe, 1'b0);
    repeat (6) @(negedge clk);
    ss_n_i = 1'b0;
    if (!ph) mosi_i = mtx[7];
    repeat (6) @(negedge clk);
    check("R10 miso driven when selected", miso_oe, 1'b1);
    cap = '0;
    for (int b = 7; b >= 0; b--) begin
      if (!ph) begin
        cap = {cap[6:0], miso_o};
        sck_i = ~pol; repeat (6) @(negedge clk);
        sck_i = pol; mosi_i = (b > 0) ? mtx[b-1] : 1'b0; repeat (6) @(negedge clk);
      end else begin
        sck_i = ~pol; mosi_i = mtx[b]; repeat (6) @(negedge clk);
        cap = {cap[6:0], miso_o};
        sck_i = pol; repeat (6) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    check("R10 slave completion raises irq", irq, 1'b1);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 miso released after deselect", miso_oe, 1'b0);
    reg_read(2'd1, d); check("R10 slave status", d, 8'h80);
    reg_read(2'd2, d); check("R10 slave received byte", d, mtx);
    check("R10 slave sent byte", cap, stx);
  endtask

  task automatic t_modf();
    logic [7:0] d;
    reg_write(2'd0, cbyte(1, 0, 1, 0, 0, 2'd0));
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 outputs released", {sck_oe, mosi_oe}, 2'b00);
    reg_read(2'd0, d); check("R11 master bit cleared", d, 8'h01);
    reg_read(2'd1, d); check("R11 R9 fault flag at bit 4", d, 8'h10);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    reg_write(2'd0, cbyte(1, 0, 1, 0, 0, 2'd0));
    reg_read(2'd1, d); check("R11 fault cleared by control write", d, 8'h00);
    check("R11 master drives again", sck_oe, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_master(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C);
    t_master(1'b1, 1'b0, 2'd1, 8'h81, 8'h7E);
    t_master(1'b0, 1'b1, 2'd2, 8'h69, 8'hD2);
    t_master(1'b1, 1'b1, 2'd3, 8'h1F, 8'hE4);
    t_handshake();
    t_wcol();
    t_slave(1'b0, 1'b0, 2'd0, 8'hC6, 8'h2B);
    t_slave(1'b1, 1'b1, 2'd3, 8'h59, 8'hA7);
    t_slave(1'b0, 1'b0, 2'd3, 8'hC6, 8'h2B);
    t_modf();
    summary();
  end

endmodule